// File: doc/BRIEF.md
# UTOPIA Receive Cell Reader

This block sits on the ATM-layer side of a single-PHY UTOPIA receive link and pulls 53-byte cells out of the PHY device. It watches the PHY's cell-available flag and drives the active-low read enable. It captures the 8-bit data bus together with the start-of-cell strobe and the parity bit. It hands each byte downstream as a registered stream with start, end, parity-error and misalignment flags.

Reading starts only when the PHY reports a cell and the downstream side is ready. Once a cell has started, read enable stays low for all 53 byte slots. The cell-available level seen during the last byte slot decides what happens next. If it is high and downstream is ready, the next cell follows with no gap. Otherwise read enable rises and the reader waits.

The PHY puts a byte on the bus one clock after it samples read enable low, and the block registers it once more before presenting it. Framing is kept by a received-byte counter, which is checked against the one-clock start-of-cell strobe.

Top module: `utopia_rx_reader`

## Requirements
- R1: Reset is synchronous and active high. While it is held and in the cycle after it, `phy_enb_n` is 1 and `out_valid` is 0.
- R2: `phy_enb_n` goes low only on the clock after a cycle in which, with the reader idle, both `phy_clav` and `dn_ready` were high.
- R3: A byte read with `phy_enb_n` low at clock edge k is on the bus during the following cycle. It appears on the output with `out_valid`=1 after edge k+2, and `out_data` equals that bus byte.
- R4: Once a cell is started, `phy_enb_n` stays low for exactly 53 consecutive cycles. If `phy_clav` and `dn_ready` are both high during the 53rd, the next cell starts at once with no gap.
- R5: If `phy_clav` is low during the 53rd read-enable cycle of a cell, `phy_enb_n` is 1 in the next cycle and stays there until R2 allows a restart.
- R6: `out_sop`=1 marks a byte received with `phy_soc`=1; that byte is count 1. `out_eop`=1 marks the byte whose count reaches 53. No flag is set while `out_valid`=0.
- R7: With `par_en`=1, `out_perr`=1 exactly when the byte and its `phy_prty` bit together hold an even number of ones (odd parity expected).
- R8: With `par_en`=0, `out_perr` is 0 whatever the parity bit.
- R9: A `phy_soc` strobe at any count other than an expected cell start sets `out_misalign` for that byte and restarts the count at 1. An expected start is reset-fresh, or after count 53.
- R10: A byte without `phy_soc` where a cell start is expected sets `out_misalign`. It is not counted, and each further byte is flagged the same way until a strobe arrives.
- R11: `dn_ready`=0 never ends a cell in progress early. It only blocks the start of a new cell, both from idle and at the 53rd byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive interface clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_clav | input | 1 | Cell available from the PHY |
| phy_data | input | 8 | Receive data bus |
| phy_soc | input | 1 | Start-of-cell strobe from the PHY |
| phy_prty | input | 1 | Odd parity bit of `phy_data` |
| par_en | input | 1 | Enables the parity comparison |
| dn_ready | input | 1 | Downstream can accept a new cell |
| phy_enb_n | output | 1 | Active-low read enable to the PHY |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a cell |
| out_eop | output | 1 | 53rd byte of a cell |
| out_perr | output | 1 | Parity mismatch on this byte |
| out_misalign | output | 1 | Start strobe missing or unexpected on this byte |

## Verification
The first stretch holds cell-available and ready high for several cells. Any pause between cells or a wrong length of the enable run shows up here. A forced low on cell-available at the end of that stretch separates the stop-at-boundary path from continuation.

A long random stretch then toggles cell-available, ready and parity enable. It also injects wrong parity bits and occasionally adds or drops start strobes. These inputs separate the restart rule, the ready gating, parity enable on versus off, and the two misalignment cases: a strobe at the wrong count and a missing strobe. Every cycle compares read enable and every output field with a bench model.

// File: rtl/utopia_rx_reader.sv
module utopia_rx_reader #(
  parameter int CELL_BYTES = 53,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phy_clav,
  input  logic [DW-1:0] phy_data,
  input  logic          phy_soc,
  input  logic          phy_prty,
  input  logic          par_en,
  input  logic          dn_ready,
  output logic          phy_enb_n,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_perr,
  output logic          out_misalign
);
  localparam int CW = $clog2(CELL_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(CELL_BYTES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] iss_cnt, rx_cnt, rx_next;
  logic bus_live, mis_next;

  wire start_ok   = phy_clav & dn_ready;
  wire at_last    = (iss_cnt == LAST);
  wire want_first = (rx_cnt == '0) || (rx_cnt == LAST);
  wire par_bad    = par_en & ~(^{phy_data, phy_prty});

  always_comb begin
    if (phy_soc) begin
      rx_next  = ONE;
      mis_next = ~want_first;
    end else if (want_first) begin
      rx_next  = '0;
      mis_next = 1'b1;
    end else begin
      rx_next  = rx_cnt + ONE;
      mis_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_enb_n <= 1'b1;
      iss_cnt   <= '0;
      bus_live  <= 1'b0;
    end else begin
      bus_live <= ~phy_enb_n;
      if (phy_enb_n) begin
        if (start_ok) begin
          phy_enb_n <= 1'b0;
          iss_cnt   <= ONE;
        end
      end else if (at_last) begin
        if (start_ok) iss_cnt <= ONE;
        else begin
          phy_enb_n <= 1'b1;
          iss_cnt   <= '0;
        end
      end else begin
        iss_cnt <= iss_cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt       <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sop      <= 1'b0;
      out_eop      <= 1'b0;
      out_perr     <= 1'b0;
      out_misalign <= 1'b0;
    end else begin
      out_valid <= bus_live;
      if (bus_live) begin
        rx_cnt       <= rx_next;
        out_data     <= phy_data;
        out_sop      <= phy_soc;
        out_eop      <= (rx_next == LAST);
        out_perr     <= par_bad;
        out_misalign <= mis_next;
      end else begin
        out_sop      <= 1'b0;
        out_eop      <= 1'b0;
        out_perr     <= 1'b0;
        out_misalign <= 1'b0;
      end
    end
  end

  assert_enb_needs_clav_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_enb_n) |-> $past(phy_clav && dn_ready));

  assert_byte_latency_R3: assert property (@(posedge clk) disable iff (rst)
    !phy_enb_n |=> ##1 out_valid);

  assert_hold_in_cell_R4: assert property (@(posedge clk) disable iff (rst)
    (!phy_enb_n && !at_last) |=> !phy_enb_n);

  assert_back_to_back_R4: assert property (@(posedge clk) disable iff (rst)
    (!phy_enb_n && at_last && phy_clav && dn_ready) |=> !phy_enb_n);

  assert_stop_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    (!phy_enb_n && at_last && !phy_clav) |=> phy_enb_n);

  assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_sop || out_eop || out_perr || out_misalign));

  assert_parity_off_R8: assert property (@(posedge clk) disable iff (rst)
    !par_en |=> !out_perr);

  assert_ready_gates_start_R11: assert property (@(posedge clk) disable iff (rst)
    (phy_enb_n && !dn_ready) |=> phy_enb_n);
endmodule

// File: tb/utopia_rx_reader_bench.sv
`timescale 1ns/1ps
module utopia_rx_reader_bench;
  localparam int CELL = 53;
  localparam int CYCLES = 30000;

  logic clk = 1'b0;
  logic rst, phy_clav, phy_soc, phy_prty, par_en, dn_ready;
  logic [7:0] phy_data;
  logic phy_enb_n, out_valid, out_sop, out_eop, out_perr, out_misalign;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  utopia_rx_reader u_utopia_rx_reader (
    .clk(clk), .rst(rst), .phy_clav(phy_clav), .phy_data(phy_data),
    .phy_soc(phy_soc), .phy_prty(phy_prty), .par_en(par_en), .dn_ready(dn_ready),
    .phy_enb_n(phy_enb_n), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_perr(out_perr),
    .out_misalign(out_misalign));

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  // PHY model and expectations
  logic bus_v;
  int pidx, ecnt, rcnt;
  logic inj_par, inj_soc;
  logic exp_enb_n, exp_v, exp_sop, exp_eop, exp_perr, exp_mis;
  logic [7:0] exp_data;

  function automatic logic odd_bit(input logic [7:0] d);
    return ~(^d);
  endfunction

  function automatic logic parity_bad(input logic en, input logic [7:0] d, input logic p);
    return en & ~(^{d, p});
  endfunction

  function automatic logic start_expected(input int c);
    return (c == 0) || (c == CELL);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ecnt = 0; rcnt = 0; pidx = 0;
      exp_enb_n = 1'b1; exp_v = 1'b0;
      exp_sop = 0; exp_eop = 0; exp_perr = 0; exp_mis = 0; exp_data = '0;
      bus_v <= 1'b0;
    end else begin
      // output expectation for the byte on the bus now
      exp_v = bus_v;
      if (bus_v) begin
        exp_data = phy_data;
        exp_sop  = phy_soc;
        exp_perr = parity_bad(par_en, phy_data, phy_prty);
        if (phy_soc) begin
          exp_mis = !start_expected(rcnt);
          rcnt = 1;
        end else if (start_expected(rcnt)) begin
          exp_mis = 1'b1;
          rcnt = 0;
        end else begin
          exp_mis = 1'b0;
          rcnt = rcnt + 1;
        end
        exp_eop = (rcnt == CELL);
      end else begin
        exp_sop = 0; exp_eop = 0; exp_perr = 0; exp_mis = 0;
      end
      // PHY answers a read enable one clock later
      if (!phy_enb_n) begin
        logic [7:0] d;
        d = 8'($urandom);
        phy_data <= d;
        phy_prty <= odd_bit(d) ^ inj_par;
        phy_soc  <= (pidx == 0) ^ inj_soc;
        pidx = (pidx == CELL - 1) ? 0 : pidx + 1;
        bus_v <= 1'b1;
      end else begin
        bus_v <= 1'b0;
      end
      // read enable expectation
      if (phy_enb_n) begin
        if (phy_clav && dn_ready) begin exp_enb_n = 1'b0; ecnt = 1; end
        else exp_enb_n = 1'b1;
      end else if (ecnt == CELL) begin
        if (phy_clav && dn_ready) begin exp_enb_n = 1'b0; ecnt = 1; end
        else begin exp_enb_n = 1'b1; ecnt = 0; end
      end else begin
        exp_enb_n = 1'b0; ecnt = ecnt + 1;
      end
    end
  end

  task automatic check1(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic check_cycle();
    check1("R2 R4 R5 R11 phy_enb_n", phy_enb_n, exp_enb_n);
    check1("R3 out_valid", out_valid, exp_v);
    if (exp_v) begin
      vectors++;
      if (out_data !== exp_data) begin
        errors++;
        $display("FAIL R3 out_data at %0t: actual %h expected %h", $time, out_data, exp_data);
      end
    end
    check1("R6 out_sop", out_sop, exp_sop);
    check1("R6 out_eop", out_eop, exp_eop);
    check1("R7 R8 out_perr", out_perr, exp_perr);
    check1("R9 R10 out_misalign", out_misalign, exp_mis);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; phy_clav = 0; dn_ready = 0; par_en = 1;
    phy_data = '0; phy_soc = 0; phy_prty = 1;
    inj_par = 0; inj_soc = 0;
    repeat (4) @(negedge clk);
    check1("R1 phy_enb_n in reset", phy_enb_n, 1'b1);
    check1("R1 out_valid in reset", out_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check1("R1 phy_enb_n after reset", phy_enb_n, 1'b1);
    check1("R1 out_valid after reset", out_valid, 1'b0);
    for (int c = 0; c < CYCLES; c++) begin
      if (c < 4 * CELL) begin
        // directed: back-to-back cells (R4), clean framing (R6)
        phy_clav = 1; dn_ready = 1; par_en = 1; inj_par = 0; inj_soc = 0;
      end else if (c < 6 * CELL) begin
        // directed: clav low at the boundary stops reading (R5)
        phy_clav = 0; dn_ready = 1; inj_par = (c % 7 == 0); inj_soc = 0;
      end else if (c < 8 * CELL) begin
        // directed: ready low with clav high blocks the start (R11)
        phy_clav = 1; dn_ready = 0; inj_par = 0; inj_soc = 0;
      end else begin
        phy_clav = ($urandom_range(9) < 7);
        dn_ready = ($urandom_range(9) < 8);
        par_en   = $urandom_range(1);
        inj_par  = ($urandom_range(15) == 0);
        inj_soc  = ($urandom_range(149) == 0);
      end
      @(negedge clk);
      check_cycle();
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule